// File: doc/BRIEF.md
# Instruction Prefix and Operand-Size Decoder

This block sits at the front of an instruction decoder. It accepts one byte per cycle over a valid/ready handshake. Any leading prefix bytes are absorbed into a small state: a bus-lock flag, a repeat condition, a segment override, and toggles for operand width and address width. The first byte that is not a prefix is taken as the opcode. One cycle later the block presents a single decoded record. Only the prefix bytes and the opcode pass through the block. Immediate bytes and any later bytes belong to the downstream stage, which uses the reported length to skip over them.

The record gives the effective operand width and the effective address width. Both come from a mode input that selects a 16-bit or 32-bit default. For the opcode, the size bit (bit 0) chooses between a byte operand and the full width. For three short-form opcodes that carry no addressing byte, the record also gives the total instruction length in bytes. A run of prefixes longer than the permitted limit ends the instruction with an error record.

Top module: `insn_prefix_decoder`

## Requirements
- R1: Reset state: `out_valid` is 0 and `in_ready` is 1 after reset.
- R2: Byte F0h sets `out_lock`. Bytes F3h and F2h set `out_rep` to 1 and 2 respectively, and the one received last wins. Without either, `out_rep` is 0.
- R3: Segment override bytes set `out_seg` as follows: 26h→1, 2Eh→2, 36h→3, 3Eh→4, 64h→5, 65h→6. The last one received wins. Without any, `out_seg` is 0.
- R4: Byte 66h inverts the default operand width given by `mode32` (1 = 32-bit default). Several 66h bytes invert it only once.
- R5: `out_adsz32` is `mode32` inverted once if any 67h byte was present. Several 67h bytes invert it only once.
- R6: `out_opsz` is 0 (8-bit) when opcode bit 0 is 0. Otherwise it is 1 (16-bit) or 2 (32-bit), following the effective operand width.
- R7: `out_len_known` is 1 and `out_len` is set only for the following opcodes, where P is the prefix count:
  - 41h: `out_len` = 1+P
  - 04h: `out_len` = 2+P
  - 05h: `out_len` = 1+(2 or 4 by operand width)+P

  For every other opcode, both `out_len_known` and `out_len` are 0.
- R8: A prefix byte that arrives when four prefixes are already held is consumed and produces an error record. In that record `out_error` is 1, `out_opc_valid` is 0, `out_opsz` is 0 and `out_len_known` is 0, while the lock, repeat, segment and address fields reflect the four held prefixes. The following instruction starts from a clean state.
- R9: `out_valid` pulses for exactly one cycle, in the cycle after the opcode (or overflow byte) is accepted. `in_ready` is 0 in that cycle and 1 in all other cycles. `out_opcode` holds the terminating byte.
- R10: `out_pfx_cnt` reports how many prefix bytes came before the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | Default width: 1 = 32-bit, 0 = 16-bit; sampled with the opcode byte |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Record strobe, one cycle |
| out_opc_valid | output | 1 | Record ends in a real opcode |
| out_error | output | 1 | Prefix limit exceeded |
| out_opcode | output | 8 | Terminating byte |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat condition code |
| out_seg | output | 3 | Segment override code |
| out_opsz | output | 2 | Operand width code (0/1/2 = 8/16/32) |
| out_adsz32 | output | 1 | Effective address width is 32-bit |
| out_pfx_cnt | output | 3 | Prefix count |
| out_len_known | output | 1 | Length is reported |
| out_len | output | 4 | Instruction length in bytes |

## Verification
The assertions check properties that hold in every cycle:
- `in_ready` is low while a record is shown, and a record lasts only one cycle.
- A record appears only after a byte was accepted.
- The error and opcode-valid flags exclude each other, and an error record always carries a full prefix count.
- A known length appears only for the three short forms.
- A byte-size operand code matches opcode bit 0.

Only the bench scenarios can show the following:
- the prefix-to-code mappings and last-one-wins ordering;
- the single inversion caused by repeated width prefixes in either mode;
- the exact length sums;
- the clean restart after an overflow.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;

   typedef enum logic [2:0] {
      PK_NONE, PK_LOCK, PK_REP, PK_REPNE, PK_SEG, PK_OPSZ, PK_ADSZ
   } pfx_kind_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [1:0] RPT_NONE = 2'd0;
   localparam logic [1:0] RPT_EQ   = 2'd1;
   localparam logic [1:0] RPT_NE   = 2'd2;

   localparam logic [7:0] OPC_INC_CNT = 8'h41;
   localparam logic [7:0] OPC_ADD_LO  = 8'h04;
   localparam logic [7:0] OPC_ADD_ACC = 8'h05;

   typedef struct packed {
      pfx_kind_e  kind;
      logic [2:0] seg;
   } pfx_class_t;

   typedef struct packed {
      logic       lock;
      logic [1:0] rep;
      logic [2:0] seg;
      logic       op_flip;
      logic       ad_flip;
   } pfx_state_t;

endpackage

// File: rtl/pfx_classify.sv
`timescale 1ns/1ps
module pfx_classify
   import pfx_pkg::*;
(
   input  logic [7:0] byte_in,
   output pfx_class_t cls
);
   always_comb begin
      cls.kind = PK_NONE;
      cls.seg  = 3'd0;
      case (byte_in)
         8'hF0: cls.kind = PK_LOCK;
         8'hF3: cls.kind = PK_REP;
         8'hF2: cls.kind = PK_REPNE;
         8'h66: cls.kind = PK_OPSZ;
         8'h67: cls.kind = PK_ADSZ;
         8'h26: begin cls.kind = PK_SEG; cls.seg = 3'd1; end
         8'h2E: begin cls.kind = PK_SEG; cls.seg = 3'd2; end
         8'h36: begin cls.kind = PK_SEG; cls.seg = 3'd3; end
         8'h3E: begin cls.kind = PK_SEG; cls.seg = 3'd4; end
         8'h64: begin cls.kind = PK_SEG; cls.seg = 3'd5; end
         8'h65: begin cls.kind = PK_SEG; cls.seg = 3'd6; end
         default: ;
      endcase
   end
endmodule

// File: rtl/pfx_accum.sv
`timescale 1ns/1ps
module pfx_accum
   import pfx_pkg::*;
#(
   parameter int MAX_PFX = 4,
   localparam int CNT_W = $clog2(MAX_PFX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             flush,
   input  pfx_class_t       cls,
   output pfx_state_t       st,
   output logic [CNT_W-1:0] cnt,
   output logic             full
);
   assign full = (cnt == CNT_W'(MAX_PFX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= '0;
         cnt <= '0;
      end else if (flush) begin
         st  <= '0;
         cnt <= '0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         case (cls.kind)
            PK_LOCK:  st.lock    <= 1'b1;
            PK_REP:   st.rep     <= RPT_EQ;
            PK_REPNE: st.rep     <= RPT_NE;
            PK_SEG:   st.seg     <= cls.seg;
            PK_OPSZ:  st.op_flip <= 1'b1;
            PK_ADSZ:  st.ad_flip <= 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pfx_size_len.sv
`timescale 1ns/1ps
module pfx_size_len
   import pfx_pkg::*;
#(
   parameter int MAX_PFX     = 4,
   parameter bit SHORT_FORMS = 1'b1,
   localparam int CNT_W = $clog2(MAX_PFX + 1),
   localparam int LEN_W = $clog2(MAX_PFX + 6)
) (
   input  logic [7:0]       opcode,
   input  logic             mode32,
   input  logic             op_flip,
   input  logic [CNT_W-1:0] pcnt,
   output logic [1:0]       opsz,
   output logic             len_known,
   output logic [LEN_W-1:0] len
);
   logic full32;
   assign full32 = mode32 ^ op_flip;
   assign opsz   = opcode[0] ? (full32 ? SZ_WORD : SZ_HALF) : SZ_BYTE;

   generate
      if (SHORT_FORMS) begin : g_len
         logic [LEN_W-1:0] imm;
         logic             hit;
         always_comb begin
            hit = 1'b1;
            imm = '0;
            case (opcode)
               OPC_INC_CNT: imm = '0;
               OPC_ADD_LO:  imm = LEN_W'(1);
               OPC_ADD_ACC: imm = full32 ? LEN_W'(4) : LEN_W'(2);
               default:     hit = 1'b0;
            endcase
            len_known = hit;
            len       = hit ? (LEN_W'(1) + imm + LEN_W'(pcnt)) : '0;
         end
      end else begin : g_nolen
         logic unused_pcnt;
         assign unused_pcnt = ^pcnt;
         assign len_known   = 1'b0;
         assign len         = '0;
      end
   endgenerate
endmodule

// File: rtl/insn_prefix_decoder.sv
`timescale 1ns/1ps
module insn_prefix_decoder
   import pfx_pkg::*;
#(
   parameter int MAX_PFX     = 4,
   parameter bit SHORT_FORMS = 1'b1,
   localparam int CNT_W = $clog2(MAX_PFX + 1),
   localparam int LEN_W = $clog2(MAX_PFX + 6)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode32,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             in_ready,
   output logic             out_valid,
   output logic             out_opc_valid,
   output logic             out_error,
   output logic [7:0]       out_opcode,
   output logic             out_lock,
   output logic [1:0]       out_rep,
   output logic [2:0]       out_seg,
   output logic [1:0]       out_opsz,
   output logic             out_adsz32,
   output logic [CNT_W-1:0] out_pfx_cnt,
   output logic             out_len_known,
   output logic [LEN_W-1:0] out_len
);
   generate
      if (MAX_PFX < 1 || MAX_PFX > 15) begin : g_bad_cfg
         $error("MAX_PFX must be within 1..15");
      end
   endgenerate

   pfx_class_t       cls;
   pfx_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             full, accept, is_pfx, take, emit, overflow;
   logic [1:0]       opsz;
   logic             len_known;
   logic [LEN_W-1:0] len;

   assign in_ready = !out_valid;
   assign accept   = in_valid && in_ready;
   assign is_pfx   = (cls.kind != PK_NONE);
   assign take     = accept && is_pfx && !full;
   assign overflow = accept && is_pfx && full;
   assign emit     = accept && (!is_pfx || full);

   pfx_classify u_cls (
      .byte_in (in_byte),
      .cls     (cls)
   );

   pfx_accum #(.MAX_PFX(MAX_PFX)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .flush (emit),
      .cls   (cls),
      .st    (st),
      .cnt   (cnt),
      .full  (full)
   );

   pfx_size_len #(.MAX_PFX(MAX_PFX), .SHORT_FORMS(SHORT_FORMS)) u_sz (
      .opcode    (in_byte),
      .mode32    (mode32),
      .op_flip   (st.op_flip),
      .pcnt      (cnt),
      .opsz      (opsz),
      .len_known (len_known),
      .len       (len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_opc_valid <= 1'b0;
         out_error     <= 1'b0;
         out_opcode    <= '0;
         out_lock      <= 1'b0;
         out_rep       <= RPT_NONE;
         out_seg       <= '0;
         out_opsz      <= SZ_BYTE;
         out_adsz32    <= 1'b0;
         out_pfx_cnt   <= '0;
         out_len_known <= 1'b0;
         out_len       <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_opc_valid <= !overflow;
            out_error     <= overflow;
            out_opcode    <= in_byte;
            out_lock      <= st.lock;
            out_rep       <= st.rep;
            out_seg       <= st.seg;
            out_adsz32    <= mode32 ^ st.ad_flip;
            out_pfx_cnt   <= cnt;
            out_opsz      <= overflow ? SZ_BYTE : opsz;
            out_len_known <= overflow ? 1'b0 : len_known;
            out_len       <= overflow ? '0 : len;
         end
      end
   end
endmodule

// File: rtl/insn_prefix_decoder_chk.sv
`timescale 1ns/1ps
module insn_prefix_decoder_chk #(
   parameter int MAX_PFX = 4,
   localparam int CNT_W = $clog2(MAX_PFX + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_opc_valid,
   input logic             out_error,
   input logic [7:0]       out_opcode,
   input logic [1:0]       out_opsz,
   input logic [CNT_W-1:0] out_pfx_cnt,
   input logic             out_len_known
);
   a_r9_ready_low_on_record: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   a_r9_single_cycle_record: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r9_record_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   a_r8_error_excludes_opc: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_error != out_opc_valid));

   a_r8_error_full_count: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_error) |-> (out_pfx_cnt == CNT_W'(MAX_PFX)));

   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_pfx_cnt <= CNT_W'(MAX_PFX)));

   a_r7_len_short_only: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len_known) |->
         (out_opcode == 8'h41 || out_opcode == 8'h04 || out_opcode == 8'h05));

   a_r6_size_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_opc_valid) |-> ((out_opsz == 2'd0) == !out_opcode[0]));
endmodule

bind insn_prefix_decoder insn_prefix_decoder_chk #(.MAX_PFX(MAX_PFX)) u_chk (.*);

// File: tb/insn_prefix_decoder_bench.sv
`timescale 1ns/1ps
module insn_prefix_decoder_bench;
   localparam int MAX_PFX = 4;

   logic       clk = 1'b0;
   logic       rst_n, mode32, in_valid, in_ready;
   logic [7:0] in_byte, out_opcode;
   logic       out_valid, out_opc_valid, out_error, out_lock, out_adsz32, out_len_known;
   logic [1:0] out_rep, out_opsz;
   logic [2:0] out_seg, out_pfx_cnt;
   logic [3:0] out_len;

   always #2.5 clk = ~clk;

   insn_prefix_decoder u_insn_prefix_decoder (
      .clk(clk), .rst_n(rst_n), .mode32(mode32), .in_valid(in_valid), .in_byte(in_byte),
      .in_ready(in_ready), .out_valid(out_valid), .out_opc_valid(out_opc_valid),
      .out_error(out_error), .out_opcode(out_opcode), .out_lock(out_lock), .out_rep(out_rep),
      .out_seg(out_seg), .out_opsz(out_opsz), .out_adsz32(out_adsz32),
      .out_pfx_cnt(out_pfx_cnt), .out_len_known(out_len_known), .out_len(out_len)
   );

   int n_chk = 0, n_err = 0, cycles = 0;
   bit run = 0, done = 0;
   int q_byte[$];
   bit q_mode[$];

   int m_cnt = 0, m_lock = 0, m_rep = 0, m_seg = 0, m_opf = 0, m_adf = 0;
   int e_valid = 0, e_opc = 0, e_opcv = 0, e_err = 0, e_lock = 0, e_rep = 0, e_seg = 0;
   int e_adsz = 0, e_opsz = 0, e_lk = 0, e_len = 0, e_cnt = 0;

   task automatic chk(input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s got %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic put(input int b, input bit m);
      q_byte.push_back(b);
      q_mode.push_back(m);
   endtask

   // behavioural reference: returns 1 when a record is produced
   task automatic model_byte(input int b, input bit m, output int rec);
      int kind, sg, full;
      kind = 0; sg = 0; rec = 0;
      case (b)
         'hF0: kind = 1;
         'hF3: kind = 2;
         'hF2: kind = 3;
         'h26: begin kind = 4; sg = 1; end
         'h2E: begin kind = 4; sg = 2; end
         'h36: begin kind = 4; sg = 3; end
         'h3E: begin kind = 4; sg = 4; end
         'h64: begin kind = 4; sg = 5; end
         'h65: begin kind = 4; sg = 6; end
         'h66: kind = 5;
         'h67: kind = 6;
         default: kind = 0;
      endcase
      if (kind != 0 && m_cnt < MAX_PFX) begin
         m_cnt++;
         if (kind == 1) m_lock = 1;
         if (kind == 2) m_rep = 1;
         if (kind == 3) m_rep = 2;
         if (kind == 4) m_seg = sg;
         if (kind == 5) m_opf = 1;
         if (kind == 6) m_adf = 1;
      end else begin
         rec = 1;
         e_opc = b; e_err = (kind != 0); e_opcv = !e_err;
         e_lock = m_lock; e_rep = m_rep; e_seg = m_seg; e_cnt = m_cnt;
         e_adsz = (m != (m_adf != 0)) ? 1 : 0;
         if (e_err) begin
            e_opsz = 0; e_lk = 0; e_len = 0;
         end else begin
            full = (m != (m_opf != 0)) ? 32 : 16;
            e_opsz = (b % 2 == 1) ? ((full == 32) ? 2 : 1) : 0;
            e_lk = 1;
            case (b)
               'h41: e_len = 1 + m_cnt;
               'h04: e_len = 2 + m_cnt;
               'h05: e_len = 1 + full / 8 + m_cnt;
               default: begin e_lk = 0; e_len = 0; end
            endcase
         end
         m_cnt = 0; m_lock = 0; m_rep = 0; m_seg = 0; m_opf = 0; m_adf = 0;
      end
   endtask

   always @(negedge clk) begin
      if (run && !done) begin
         int rec, b;
         cycles++;
         chk("R9 out_valid", int'(out_valid), e_valid);
         chk("R9 in_ready", int'(in_ready), int'(e_valid == 0));
         if (e_valid != 0) begin
            chk("R9 opcode", int'(out_opcode), e_opc);
            chk("R8 opc_valid", int'(out_opc_valid), e_opcv);
            chk("R8 error", int'(out_error), e_err);
            chk("R2 lock", int'(out_lock), e_lock);
            chk("R2 rep", int'(out_rep), e_rep);
            chk("R3 seg", int'(out_seg), e_seg);
            chk("R5 adsz32", int'(out_adsz32), e_adsz);
            chk("R4/R6 opsz", int'(out_opsz), e_opsz);
            chk("R10 pfx_cnt", int'(out_pfx_cnt), e_cnt);
            chk("R7 len_known", int'(out_len_known), e_lk);
            chk("R7 len", int'(out_len), e_len);
         end
         rec = 0;
         if (q_byte.size() == 0) begin
            in_valid = 1'b0;
            if (e_valid == 0) done = 1;
         end else if (q_byte[0] < 0) begin
            in_valid = 1'b0;
            void'(q_byte.pop_front());
            void'(q_mode.pop_front());
         end else begin
            b = q_byte[0];
            in_valid = 1'b1;
            in_byte = 8'(b);
            mode32 = q_mode[0];
            if (e_valid == 0) begin
               void'(q_byte.pop_front());
               void'(q_mode.pop_front());
               model_byte(b, mode32, rec);
            end
         end
         e_valid = rec;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; mode32 = 1'b1;
      // short forms in both modes, with and without width prefix
      put('h41, 1);
      put('h66, 1); put('h41, 1);
      put('h66, 0); put('h41, 0);
      put('h04, 1); put(-1, 1);
      put('h05, 1);
      put('h66, 1); put('h05, 1);
      put('h05, 0); put(-1, 0); put(-1, 0);
      // lock + repeat ordering + segment, four prefixes, unknown length
      put('hF0, 1); put('hF3, 1); put('hF2, 1); put('h2E, 1); put('h90, 1);
      put('hF2, 1); put('hF3, 1); put('h8B, 1);
      // repeated width prefixes toggle once
      put('h66, 1); put('h66, 1); put('h67, 1); put('h67, 1); put('h41, 1);
      put('h67, 0); put('h00, 0);
      // every segment code, last wins
      put('h26, 1); put('h01, 1);
      put('h36, 1); put('h01, 1);
      put('h3E, 1); put('h01, 1);
      put('h64, 1); put('h01, 1);
      put('h2E, 1); put('h65, 1); put('h01, 1);
      // overflow, then clean restart
      put('h26, 1); put('h66, 1); put('hF0, 1); put('h67, 1); put('h3E, 1);
      put('h41, 1);
      put('h66, 0); put('h67, 0); put('hF3, 0); put('h64, 0); put('h65, 0);
      put('h05, 0);
      repeat (3) @(negedge clk);
      chk("R1 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 in_ready", int'(in_ready), 1);
      run = 1;
      while (!done && cycles < 5000) @(negedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog got timeout expected completion");
      end
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule